// File: doc/BRIEF.md
# Core PLL Retune Sequencer

This block retunes a core PLL and keeps the core-interface clock divider consistent with the new core rate. A request carries the target core rate in hertz and the PLL divider fields (input divider, feedback divider, output divider and band). The sequencer packs those fields into a PLL control word and writes it with power-down and bypass cleared. It then waits a fixed lock interval and samples the PLL status. It finishes with a one-cycle done pulse and a 2-bit result code.

The interface divider is a one-bit register outside this block. A value of 1 selects divide-by-2 and a value of 0 selects divide-by-1. For targets above 500 MHz, the sequencer selects divide-by-2 before the PLL is touched, so the interface never sees a fast core clock undivided. For targets at or below 500 MHz, it returns to divide-by-1 as the very last step, and only when the PLL has relocked without error. A failed retune therefore leaves the divider in its safe setting.

The lock interval is `CYCLES_PER_US * LOCK_US` system-clock cycles. It is counted by a down-counter. Requests arriving while a retune is in progress are dropped.

Top module: `core_pll_retuner`

## Requirements
- R1: After a synchronous active-low reset, and after a reset that arrives in the middle of a retune, `busy`, `done`, `pll_ctrl_we` and `ifdiv_we` are low. No done pulse follows the aborted retune. A new request is then served normally.
- R2: When the requested rate is strictly greater than 500,000,000 Hz, the block writes the interface divider with value 1 (divide by 2). This write happens in the cycle immediately before the PLL control write.
- R3: The PLL control word has these fields:
  - bits 1:0 (power-down at bit 0, bypass at bit 1) are zero;
  - the output-divider code is in bits 3:2;
  - the input-divider code is in bits 8:4;
  - the feedback code is in bits 15:9;
  - the band is in bits 23:20;
  - all other bits are zero.
- R4: If the PLL control write is in cycle k, status is sampled in cycle k+L+1, where L = CYCLES_PER_US*LOCK_US. Done follows in cycle k+L+2, or in cycle k+L+3 when a final divider write is made.
- R5: If status bit 0 (lock) is clear when sampled, the result is 01 (timeout). No divider write follows the PLL write.
- R6: If status bit 0 is set and status bit 1 (error) is set, the result is 10 (error). No divider write follows the PLL write.
- R7: On a clean lock with a rate at or below 500,000,000 Hz, the block writes the interface divider with value 0 in the cycle after sampling. Done with result 00 follows in the next cycle. On a clean lock above the threshold, done with result 00 follows with no further divider write.
- R8: `done` is a one-cycle pulse. `result` is valid while `done` is high and only takes the codes 00, 01 and 10.
- R9: `busy` is high from the cycle after a request is accepted through the done cycle, and low in the cycle after done. Requests while busy are ignored: each accepted request produces exactly one PLL control write, carrying the word captured at acceptance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Retune request, accepted when idle |
| req_rate_hz | input | 32 | Target core rate in Hz |
| req_idiv | input | 5 | PLL input-divider code |
| req_fbdiv | input | 7 | PLL feedback-divider code |
| req_odiv | input | 2 | PLL output-divider code |
| req_band | input | 4 | PLL band code |
| pll_status | input | 2 | PLL status: bit 0 lock, bit 1 error |
| pll_ctrl_we | output | 1 | Write strobe for the PLL control register |
| pll_ctrl_wdata | output | 32 | PLL control word |
| ifdiv_we | output | 1 | Write strobe for the interface divider register |
| ifdiv_wdata | output | 1 | Divider value: 1 divide by 2, 0 divide by 1 |
| busy | output | 1 | Retune in progress |
| done | output | 1 | One-cycle completion pulse |
| result | output | 2 | 00 ok, 01 timeout, 10 error |

## Verification
The assertions check the following on every cycle:
- a divide-by-2 write is always followed directly by the PLL write;
- the wait state is not left before the counter expires;
- a divide-by-1 write is only made for a low target and is followed at once by an ok done;
- done is a single-cycle pulse carrying a legal code, and each request writes the PLL once;
- the control word is not disturbed while busy.

Only the bench's scenarios can show the following:
- the exact field placement in the control word;
- the exact lock-wait length counted from the PLL write;
- the lock boundary at precisely L cycles against L+1;
- the threshold at exactly 500 MHz against one hertz more;
- that a failed retune leaves the divider setting as it was;
- the recovery from a reset in mid-retune.

// File: rtl/pll_retune_pkg.sv
// Shared field layout, result codes and state encoding for the core PLL
// retune sequencer. Field positions are fixed by the PLL control register
// that decodes them.
package pll_retune_pkg;

    localparam int CTRL_W    = 32;
    localparam int RATE_W    = 32;

    localparam int PD_BIT    = 0;
    localparam int BYP_BIT   = 1;
    localparam int ODIV_LSB  = 2;
    localparam int ODIV_W    = 2;
    localparam int IDIV_LSB  = 4;
    localparam int IDIV_W    = 5;
    localparam int FBDIV_LSB = 9;
    localparam int FBDIV_W   = 7;
    localparam int BAND_LSB  = 20;
    localparam int BAND_W    = 4;

    localparam int STAT_LOCK = 0;
    localparam int STAT_ERR  = 1;

    localparam logic IFDIV_BY1 = 1'b0;
    localparam logic IFDIV_BY2 = 1'b1;

    typedef enum logic [1:0] {
        RES_OK      = 2'b00,
        RES_TIMEOUT = 2'b01,
        RES_ERROR   = 2'b10
    } result_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_DIV_UP,
        ST_PLL_WR,
        ST_WAIT,
        ST_CHECK,
        ST_DIV_DOWN,
        ST_DONE
    } state_e;

    typedef struct packed {
        logic [BAND_W-1:0]  band;
        logic [FBDIV_W-1:0] fbdiv;
        logic [IDIV_W-1:0]  idiv;
        logic [ODIV_W-1:0]  odiv;
    } pll_cfg_t;

endpackage

// File: rtl/pll_ctrl_pack.sv
// Packs the PLL divider fields into the control-register word.
// Assumes: power-down and bypass must be written as zero on every retune;
// all unassigned bits are written as zero.
module pll_ctrl_pack
    import pll_retune_pkg::*;
(
    input  pll_cfg_t            cfg,
    output logic [CTRL_W-1:0]   word
);

    // Place each divider field at its decoded bit position.
    always_comb begin
        word                           = '0;
        word[PD_BIT]                   = 1'b0;
        word[BYP_BIT]                  = 1'b0;
        word[ODIV_LSB  +: ODIV_W]      = cfg.odiv;
        word[IDIV_LSB  +: IDIV_W]      = cfg.idiv;
        word[FBDIV_LSB +: FBDIV_W]     = cfg.fbdiv;
        word[BAND_LSB  +: BAND_W]      = cfg.band;
    end

endmodule

// File: rtl/pll_lock_timer.sv
// Down-counter that measures the PLL lock interval after a control write.
// Assumes: load is a one-cycle strobe in the PLL write cycle; run is held
// for the whole wait. Expired is high when the count has reached zero.
module pll_lock_timer #(
    parameter int CYCLES_PER_US = 200,
    parameter int LOCK_US       = 100
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    input  logic run,
    output logic expired
);

    localparam int LOCK_CYCLES = CYCLES_PER_US * LOCK_US;
    localparam int CNT_W       = (LOCK_CYCLES > 1) ? $clog2(LOCK_CYCLES + 1) : 1;

    generate
        if (LOCK_CYCLES > 1) begin : g_counter
            logic [CNT_W-1:0] cnt_q;

            // Reload on the PLL write, then count down to zero while running.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    cnt_q <= '0;
                end else if (load) begin
                    cnt_q <= CNT_W'(LOCK_CYCLES - 1);
                end else if (run && (cnt_q != '0)) begin
                    cnt_q <= cnt_q - 1'b1;
                end
            end

            assign expired = (cnt_q == '0);

            // A fresh load must never appear expired in the next cycle.
            p_no_early_expiry_r4: assert property (@(posedge clk) disable iff (!rst_n)
                load |=> !expired);
        end else begin : g_single
            logic unused_in;
            assign unused_in = load ^ run ^ clk ^ rst_n;
            assign expired   = 1'b1;
        end
    endgenerate

endmodule

// File: rtl/pll_retune_fsm.sv
// Sequencing state machine for a core PLL retune.
// Order: optional divide-by-2 write, PLL control write, lock wait, status
// check, optional divide-by-1 write, done pulse.
// Assumes: status is stable when sampled in the check state; requests are
// only taken in the idle state.
module pll_retune_fsm
    import pll_retune_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        req_valid,
    input  logic        req_above,
    input  logic        pll_lock,
    input  logic        pll_err,
    input  logic        timer_expired,
    output logic        capture,
    output logic        timer_load,
    output logic        timer_run,
    output logic        pll_we,
    output logic        ifdiv_we,
    output logic        ifdiv_wdata,
    output logic        busy,
    output logic        done,
    output logic [1:0]  result
);

    state_e  state_q, state_d;
    logic    above_q;
    result_e result_q, result_d;

    // Next-state and result selection.
    always_comb begin
        state_d  = state_q;
        result_d = result_q;
        unique case (state_q)
            ST_IDLE:     if (req_valid) state_d = req_above ? ST_DIV_UP : ST_PLL_WR;
            ST_DIV_UP:   state_d = ST_PLL_WR;
            ST_PLL_WR:   state_d = ST_WAIT;
            ST_WAIT:     if (timer_expired) state_d = ST_CHECK;
            ST_CHECK: begin
                if (!pll_lock) begin
                    result_d = RES_TIMEOUT;
                    state_d  = ST_DONE;
                end else if (pll_err) begin
                    result_d = RES_ERROR;
                    state_d  = ST_DONE;
                end else begin
                    result_d = RES_OK;
                    state_d  = above_q ? ST_DONE : ST_DIV_DOWN;
                end
            end
            ST_DIV_DOWN: state_d = ST_DONE;
            ST_DONE:     state_d = ST_IDLE;
            default:     state_d = ST_IDLE;
        endcase
    end

    // State, latched threshold flag and result registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= ST_IDLE;
            above_q  <= 1'b0;
            result_q <= RES_OK;
        end else begin
            state_q  <= state_d;
            result_q <= result_d;
            if (capture) begin
                above_q <= req_above;
            end
        end
    end

    // Decode strobes from the current state.
    always_comb begin
        capture     = (state_q == ST_IDLE) && req_valid;
        pll_we      = (state_q == ST_PLL_WR);
        timer_load  = pll_we;
        timer_run   = (state_q == ST_WAIT);
        ifdiv_we    = (state_q == ST_DIV_UP) || (state_q == ST_DIV_DOWN);
        ifdiv_wdata = (state_q == ST_DIV_UP) ? IFDIV_BY2 : IFDIV_BY1;
        busy        = (state_q != ST_IDLE);
        done        = (state_q == ST_DONE);
        result      = result_q;
    end

    p_div_up_then_pll_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (ifdiv_we && ifdiv_wdata == IFDIV_BY2) |=> pll_we);

    p_wait_holds_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_WAIT && !timer_expired) |=> (state_q == ST_WAIT));

    p_check_after_expiry_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_CHECK) |-> $past(timer_expired));

    p_timeout_result_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_CHECK && !pll_lock) |=> (done && result == RES_TIMEOUT && !ifdiv_we));

    p_error_result_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_CHECK && pll_lock && pll_err) |=> (done && result == RES_ERROR && !ifdiv_we));

    p_div_down_last_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (ifdiv_we && ifdiv_wdata == IFDIV_BY1) |=> (done && result == RES_OK));

    p_div_down_low_only_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (ifdiv_we && ifdiv_wdata == IFDIV_BY1) |-> !above_q);

    p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_result_legal_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (result != 2'b11));

    p_single_pll_write_r9: assert property (@(posedge clk) disable iff (!rst_n)
        pll_we |=> !pll_we);

    p_idle_after_done_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !busy);

endmodule

// File: rtl/core_pll_retuner.sv
// Top of the core PLL retune sequencer. Captures a request, compares the
// target rate with the interface-divider threshold, packs the control word
// and drives the register writes through the sequencing state machine.
// Assumes: pll_status is already synchronous to clk.
module core_pll_retuner
    import pll_retune_pkg::*;
#(
    parameter int          CYCLES_PER_US = 200,
    parameter int          LOCK_US       = 100,
    parameter int unsigned THRESH_HZ     = 32'd500_000_000
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                req_valid,
    input  logic [RATE_W-1:0]   req_rate_hz,
    input  logic [IDIV_W-1:0]   req_idiv,
    input  logic [FBDIV_W-1:0]  req_fbdiv,
    input  logic [ODIV_W-1:0]   req_odiv,
    input  logic [BAND_W-1:0]   req_band,
    input  logic [1:0]          pll_status,
    output logic                pll_ctrl_we,
    output logic [CTRL_W-1:0]   pll_ctrl_wdata,
    output logic                ifdiv_we,
    output logic                ifdiv_wdata,
    output logic                busy,
    output logic                done,
    output logic [1:0]          result
);

    pll_cfg_t           req_cfg;
    logic [CTRL_W-1:0]  packed_word;
    logic [CTRL_W-1:0]  ctrl_q;
    logic               req_above;
    logic               capture;
    logic               timer_load;
    logic               timer_run;
    logic               timer_expired;

    // Gather the request fields and compare the rate with the threshold.
    always_comb begin
        req_cfg.band  = req_band;
        req_cfg.fbdiv = req_fbdiv;
        req_cfg.idiv  = req_idiv;
        req_cfg.odiv  = req_odiv;
        req_above     = (req_rate_hz > RATE_W'(THRESH_HZ));
    end

    pll_ctrl_pack u_pack (
        .cfg  (req_cfg),
        .word (packed_word)
    );

    // Hold the packed control word from acceptance until the next request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= '0;
        end else if (capture) begin
            ctrl_q <= packed_word;
        end
    end

    pll_lock_timer #(
        .CYCLES_PER_US (CYCLES_PER_US),
        .LOCK_US       (LOCK_US)
    ) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (timer_load),
        .run     (timer_run),
        .expired (timer_expired)
    );

    pll_retune_fsm u_fsm (
        .clk           (clk),
        .rst_n         (rst_n),
        .req_valid     (req_valid),
        .req_above     (req_above),
        .pll_lock      (pll_status[STAT_LOCK]),
        .pll_err       (pll_status[STAT_ERR]),
        .timer_expired (timer_expired),
        .capture       (capture),
        .timer_load    (timer_load),
        .timer_run     (timer_run),
        .pll_we        (pll_ctrl_we),
        .ifdiv_we      (ifdiv_we),
        .ifdiv_wdata   (ifdiv_wdata),
        .busy          (busy),
        .done          (done),
        .result        (result)
    );

    assign pll_ctrl_wdata = ctrl_q;

    p_pd_bypass_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
        pll_ctrl_we |-> (pll_ctrl_wdata[PD_BIT] == 1'b0 && pll_ctrl_wdata[BYP_BIT] == 1'b0));

    p_req_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !done) |=> $stable(ctrl_q));

endmodule

// File: tb/core_pll_retuner_bench.sv
`timescale 1ns/1ps
module core_pll_retuner_bench;

    localparam int CPU = 2;
    localparam int LUS = 100;
    localparam int L   = CPU * LUS;

    typedef struct packed {
        logic [31:0] rate;
        logic [4:0]  idiv;
        logic [6:0]  fb;
        logic [1:0]  od;
        logic [3:0]  band;
        logic [15:0] delay;
        logic        err;
        logic [1:0]  res;
        logic        pre;
        logic        post;
    } vec_t;

    localparam int NV = 12;
    localparam vec_t VECS [NV] = '{
        '{32'd800_000_000,  5'd0, 7'd23, 2'd1, 4'd0,  16'd10,  1'b0, 2'b00, 1'b1, 1'b0},
        '{32'd400_000_000,  5'd1, 7'd47, 2'd2, 4'd0,  16'd10,  1'b0, 2'b00, 1'b0, 1'b1},
        '{32'd500_000_000,  5'd0, 7'd14, 2'd1, 4'd0,  16'd10,  1'b0, 2'b00, 1'b0, 1'b1},
        '{32'd500_000_001,  5'd0, 7'd14, 2'd1, 4'd0,  16'd10,  1'b0, 2'b00, 1'b1, 1'b0},
        '{32'd1000_000_000, 5'd1, 7'd29, 2'd0, 4'd0,  16'd999, 1'b0, 2'b01, 1'b1, 1'b0},
        '{32'd300_000_000,  5'd1, 7'd35, 2'd2, 4'd0,  16'd999, 1'b0, 2'b01, 1'b0, 1'b0},
        '{32'd600_000_000,  5'd0, 7'd17, 2'd1, 4'd0,  16'd10,  1'b1, 2'b10, 1'b1, 1'b0},
        '{32'd200_000_000,  5'd1, 7'd47, 2'd3, 4'd0,  16'd10,  1'b1, 2'b10, 1'b0, 1'b0},
        '{32'd1600_000_000, 5'd1, 7'd47, 2'd0, 4'd15, 16'd10,  1'b0, 2'b00, 1'b1, 1'b0},
        '{32'd450_000_000,  5'd0, 7'd20, 2'd1, 4'd5,  16'd200, 1'b0, 2'b00, 1'b0, 1'b1},
        '{32'd450_000_000,  5'd0, 7'd20, 2'd1, 4'd5,  16'd201, 1'b0, 2'b01, 1'b0, 1'b0},
        '{32'd100_000_000,  5'd0, 7'd11, 2'd3, 4'd0,  16'd0,   1'b0, 2'b00, 1'b0, 1'b1}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [31:0] req_rate_hz = '0;
    logic [4:0]  req_idiv = '0;
    logic [6:0]  req_fbdiv = '0;
    logic [1:0]  req_odiv = '0;
    logic [3:0]  req_band = '0;
    logic [1:0]  pll_status;
    logic        pll_ctrl_we;
    logic [31:0] pll_ctrl_wdata;
    logic        ifdiv_we;
    logic        ifdiv_wdata;
    logic        busy;
    logic        done;
    logic [1:0]  result;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    core_pll_retuner #(.CYCLES_PER_US(CPU), .LOCK_US(LUS)) u_core_pll_retuner (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_rate_hz(req_rate_hz),
        .req_idiv(req_idiv), .req_fbdiv(req_fbdiv), .req_odiv(req_odiv), .req_band(req_band),
        .pll_status(pll_status), .pll_ctrl_we(pll_ctrl_we), .pll_ctrl_wdata(pll_ctrl_wdata),
        .ifdiv_we(ifdiv_we), .ifdiv_wdata(ifdiv_wdata), .busy(busy), .done(done), .result(result)
    );

    // Behavioural PLL status stub: locks a programmable number of cycles after a write.
    logic [15:0] stub_delay = 16'd10;
    logic        stub_err = 1'b0;
    logic [15:0] stub_cnt = 16'hFFFF;
    always @(posedge clk) begin
        if (pll_ctrl_we) stub_cnt <= 16'd0;
        else if (stub_cnt != 16'hFFFF) stub_cnt <= stub_cnt + 16'd1;
    end
    assign pll_status = {stub_err && (stub_cnt >= stub_delay), stub_cnt >= stub_delay};

    // Negedge monitor: stamps events and models the interface divider register.
    int   cyc = 0;
    int   n_pll, pll_cyc, pre_cnt, pre_cyc, post_cnt, post_cyc, done_cnt, done_cyc;
    logic pre_val, post_val, done_prev;
    logic [31:0] pll_word;
    logic [1:0]  done_res;
    logic ifdiv_model = 1'b0;
    int   width_err = 0;

    task automatic clear_mon();
        n_pll = 0; pll_cyc = 0; pre_cnt = 0; pre_cyc = 0; post_cnt = 0; post_cyc = 0;
        done_cnt = 0; done_cyc = 0; pre_val = 1'b0; post_val = 1'b1; pll_word = '0; done_res = 2'b11;
    endtask

    initial clear_mon();
    initial done_prev = 1'b0;

    always @(negedge clk) begin
        cyc <= cyc + 1;
        if (pll_ctrl_we) begin n_pll = n_pll + 1; pll_cyc = cyc; pll_word = pll_ctrl_wdata; end
        if (ifdiv_we) begin
            ifdiv_model = ifdiv_wdata;
            if (n_pll == 0) begin pre_cnt = pre_cnt + 1; pre_cyc = cyc; pre_val = ifdiv_wdata; end
            else begin post_cnt = post_cnt + 1; post_cyc = cyc; post_val = ifdiv_wdata; end
        end
        if (done) begin done_cnt = done_cnt + 1; done_cyc = cyc; done_res = result; end
        if (done && done_prev) width_err = width_err + 1;
        done_prev = done;
    end

    task automatic check(input bit ok, input string req, input string what, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic send(input vec_t v);
        @(negedge clk);
        req_rate_hz = v.rate; req_idiv = v.idiv; req_fbdiv = v.fb; req_odiv = v.od; req_band = v.band;
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic wait_done(output bit ok);
        ok = 1'b0;
        for (int i = 0; i < 2000; i++) begin
            @(negedge clk);
            #0.1;
            if (done_cnt > 0) begin ok = 1'b1; break; end
        end
    endtask

    // Watchdog.
    initial begin
        #(5.0 * 150000);
        errors++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    logic exp_div;

    initial begin
        exp_div = 1'b0;
        repeat (3) @(negedge clk);
        // R1: reset state
        check(!busy && !done && !pll_ctrl_we && !ifdiv_we, "R1", "outputs in reset", {busy, done, pll_ctrl_we, ifdiv_we}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(!busy && !done, "R1", "idle after reset", {busy, done}, 0);

        for (int k = 0; k < NV; k++) begin
            vec_t v = VECS[k];
            bit ok;
            longint exp_word;
            stub_delay = v.delay; stub_err = v.err;
            @(negedge clk);
            clear_mon();
            send(v);
            // R9: busy after acceptance, and a conflicting request while busy
            repeat (20) @(negedge clk);
            check(busy == 1'b1, "R9", "busy mid retune", busy, 1);
            req_rate_hz = 32'd999; req_idiv = 5'd31; req_fbdiv = 7'd1; req_odiv = 2'd0; req_band = 4'd9;
            req_valid = 1'b1;
            repeat (3) @(negedge clk);
            req_valid = 1'b0;
            wait_done(ok);
            check(ok, "R8", "done seen", ok, 1);
            exp_word = (longint'(v.band) << 20) | (longint'(v.fb) << 9) | (longint'(v.idiv) << 4) | (longint'(v.od) << 2);
            check(n_pll == 1, "R9", "pll writes per request", n_pll, 1);
            check(pll_word == exp_word, "R3", "control word", pll_word, exp_word);
            check(done_res == v.res, (v.res == 2'b01) ? "R5" : (v.res == 2'b10) ? "R6" : "R7", "result code", done_res, v.res);
            check(pre_cnt == int'(v.pre), "R2", "divide-by-2 pre write count", pre_cnt, v.pre);
            if (v.pre) begin
                check(pre_val == 1'b1 && pre_cyc == pll_cyc - 1, "R2", "pre write value/cycle", pre_cyc, pll_cyc - 1);
            end
            check(post_cnt == int'(v.post), "R7", "divide-by-1 post write count", post_cnt, v.post);
            if (v.post) begin
                check(post_val == 1'b0 && done_cyc == post_cyc + 1, "R7", "post write last", post_cyc, done_cyc - 1);
            end
            check(done_cyc - pll_cyc == L + 2 + int'(v.post), "R4", "write-to-done cycles", done_cyc - pll_cyc, L + 2 + int'(v.post));
            if (v.pre) exp_div = 1'b1;
            else if (v.post) exp_div = 1'b0;
            check(ifdiv_model == exp_div, (v.res != 2'b00) ? "R5" : "R7", "divider setting after retune", ifdiv_model, exp_div);
            @(negedge clk);
            check(!busy && !done, "R9", "idle after done", {busy, done}, 0);
        end
        check(width_err == 0, "R8", "done pulse width", width_err, 0);

        // R1: reset in the middle of a retune
        stub_delay = 16'd10; stub_err = 1'b0;
        clear_mon();
        send(VECS[0]);
        repeat (30) @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        check(!busy && !done && !pll_ctrl_we && !ifdiv_we, "R1", "outputs during mid-retune reset", {busy, done, pll_ctrl_we, ifdiv_we}, 0);
        rst_n = 1'b1;
        repeat (L + 20) @(negedge clk);
        check(done_cnt == 0, "R1", "no done after abort", done_cnt, 0);
        clear_mon();
        send(VECS[1]);
        begin
            bit ok;
            wait_done(ok);
            check(ok && done_res == 2'b00 && n_pll == 1, "R1", "retune after abort", done_res, 0);
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule